// File: doc/BRIEF.md
# Tagged Four-Port Calculator with Split Arithmetic and Shift Pipelines

This block serves several requesters, four by default, with 32-bit integer arithmetic. Each requester port presents a command with an opcode, a 2-bit tag and two operands, and gets the accepted command back later as a response. The response carries the same tag, a response code and a result word. A port may have up to four commands outstanding. Inside the block, add, subtract and unknown opcodes share one arithmetic queue and pipeline. Left and right shifts share a second queue and a deeper pipeline. Results from the two pipelines can therefore come back to one port in a different order from the one in which the commands went in. Within one pipeline they keep their order.

Each queue accepts one command per cycle. Ports that compete for a queue are served in rotating order, and a port only sees its ready signal high in the cycle its command is taken. A command stays presented until it is taken, so nothing is dropped. Each port has a single response lane. If both pipelines finish work for the same port in the same cycle, the arithmetic result is delivered and the whole shift pipeline stalls for that cycle.

Top module: `mtc_tagged_calc`

## Requirements
- R1: A port never has more than MAX_OUT (default 4) accepted commands without a response, and its ready stays low while it has MAX_OUT outstanding.
- R2: Every accepted command produces exactly one response on its own port. That response carries the command's tag and a nonzero code: 2'b01 for success, 2'b10 for error.
- R3: Opcode 4'h1 adds the operands. The data is the sum modulo 2^32. The code is 2'b10 when the sum carries out of bit 31 (FFFFFFFF plus 1 gives data 0), otherwise 2'b01.
- R4: Opcode 4'h2 subtracts the second operand from the first. The data is the difference modulo 2^32. The code is 2'b10 when the second operand is larger, otherwise 2'b01. Equal operands give data 0 with code 2'b01.
- R5: Opcodes 4'h5 and 4'h6 shift the first operand logically left and right. The amount is the low 5 bits of the second operand, so 0 and 31 are both valid amounts. The code is 2'b01.
- R6: Any other opcode gets a response with code 2'b10 and data 0. It is ordered together with that port's add and subtract commands.
- R7: On one port, responses to commands of the arithmetic class (4'h1, 4'h2, invalid) come back in issue order, and responses to shifts come back in issue order.
- R8: Each queue takes at most one command per cycle. Competing ports are granted in rotating order. A command held off by a full queue or a lost arbitration stays pending and is executed later.
- R9: An idle arithmetic path responds in the second cycle after acceptance, and an idle shift path in the third. When both finish for one port in the same cycle, the arithmetic response goes first and the shift response follows one cycle later.
- R10: rsp_valid is low during and right after reset. A port's response lane only carries a response for a command that port issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Command presented, one bit per port |
| req_ready | output | NP | Command taken at this edge, one bit per port |
| req_op | input | NP x 4 | Opcode per port |
| req_tag | input | NP x TW | Command tag per port |
| req_a | input | NP x DW | First operand per port |
| req_b | input | NP x DW | Second operand or shift amount per port |
| rsp_valid | output | NP | Response present, one bit per port |
| rsp_code | output | NP x 2 | Response code: 01 success, 10 error |
| rsp_tag | output | NP x TW | Tag of the command answered |
| rsp_data | output | NP x DW | Result word |

## Verification
The arithmetic and shift pipelines can finish work for the same port in the same edge. The directed test provokes this on one port by issuing a shift and then, in the next cycle, an add. The shift's extra stage makes both results due together. The test checks that the add's tag appears first and the shift's tag one cycle later. Concurrent mixed traffic from all ports then causes such collisions without a fixed schedule. A scoreboard judges every response by its tag against the head of the matching per-port, per-class expectation queue, so a lost, duplicated or swapped shift result shows up as an error.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   localparam logic [3:0] OP_ADD = 4'h1;
   localparam logic [3:0] OP_SUB = 4'h2;
   localparam logic [3:0] OP_SHL = 4'h5;
   localparam logic [3:0] OP_SHR = 4'h6;

   localparam logic [1:0] RSP_NONE = 2'b00;
   localparam logic [1:0] RSP_OK   = 2'b01;
   localparam logic [1:0] RSP_ERR  = 2'b10;

   typedef enum logic [0:0] {UNIT_ARITH = 1'b0, UNIT_SHIFT = 1'b1} unit_kind_e;

   function automatic logic is_shift_op(input logic [3:0] op);
      return (op == OP_SHL) || (op == OP_SHR);
   endfunction
endpackage

// File: rtl/mtc_fifo.sv
module mtc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mtc_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/mtc_rr_arb.sv
module mtc_rr_arb #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   input  logic                 en,
   output logic [N-1:0]         gnt,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("mtc_rr_arb: N must be at least 2");
   end

   logic [IW-1:0] ptr;

   always_comb begin
      gnt = '0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         int j;
         j = int'(ptr) + i;
         if (j >= N) j = j - N;
         if (en && req[j] && (gnt == '0)) begin
            gnt[j] = 1'b1;
            idx    = IW'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else if (|gnt) ptr <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
   end

   p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/mtc_exec_unit.sv
module mtc_exec_unit
   import mtc_pkg::*;
#(
   parameter unit_kind_e KIND  = UNIT_ARITH,
   parameter int         DW    = 32,
   parameter int         TW    = 2,
   parameter int         PW    = 2,
   parameter int         DEPTH = 4,
   parameter int         LAT   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_push,
   input  logic [PW-1:0] in_port,
   input  logic [TW-1:0] in_tag,
   input  logic [3:0]    in_op,
   input  logic [DW-1:0] in_a,
   input  logic [DW-1:0] in_b,
   output logic          q_full,
   input  logic          hold,
   output logic          out_valid,
   output logic [PW-1:0] out_port,
   output logic [TW-1:0] out_tag,
   output logic [1:0]    out_code,
   output logic [DW-1:0] out_data
);
   localparam int EW = PW + TW + 4 + 2 * DW;
   localparam int SW = $clog2(DW);

   if (LAT < 1) begin : g_bad_lat
      $error("mtc_exec_unit: LAT must be at least 1");
   end

   logic [EW-1:0] q_dout;
   logic          q_empty, pop;
   logic [PW-1:0] h_port;
   logic [TW-1:0] h_tag;
   logic [3:0]    h_op;
   logic [DW-1:0] h_a, h_b, r_data;
   logic [1:0]    r_code;

   assign pop = !q_empty && !hold;

   mtc_fifo #(.W(EW), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(in_push),
      .din({in_port, in_tag, in_op, in_a, in_b}),
      .pop(pop), .dout(q_dout), .full(q_full), .empty(q_empty)
   );

   assign {h_port, h_tag, h_op, h_a, h_b} = q_dout;

   if (KIND == UNIT_ARITH) begin : g_arith
      logic [DW:0] sum;
      always_comb begin
         sum = {1'b0, h_a} + {1'b0, h_b};
         case (h_op)
            OP_ADD: begin
               r_data = sum[DW-1:0];
               r_code = sum[DW] ? RSP_ERR : RSP_OK;
            end
            OP_SUB: begin
               r_data = h_a - h_b;
               r_code = (h_b > h_a) ? RSP_ERR : RSP_OK;
            end
            default: begin
               r_data = '0;
               r_code = RSP_ERR;
            end
         endcase
      end
   end else begin : g_shift
      logic [SW-1:0] amt;
      logic          unused_hi;
      assign amt       = h_b[SW-1:0];
      assign unused_hi = ^h_b[DW-1:SW];
      always_comb begin
         case (h_op)
            OP_SHL: begin
               r_data = h_a << amt;
               r_code = RSP_OK;
            end
            OP_SHR: begin
               r_data = h_a >> amt;
               r_code = RSP_OK;
            end
            default: begin
               r_data = '0;
               r_code = RSP_ERR;
            end
         endcase
      end
   end

   logic [LAT-1:0] st_v;
   logic [PW-1:0]  st_port [LAT];
   logic [TW-1:0]  st_tag  [LAT];
   logic [1:0]     st_code [LAT];
   logic [DW-1:0]  st_data [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_v <= '0;
         for (int k = 0; k < LAT; k++) begin
            st_port[k] <= '0;
            st_tag[k]  <= '0;
            st_code[k] <= RSP_NONE;
            st_data[k] <= '0;
         end
      end else if (!hold) begin
         st_v[0]    <= pop;
         st_port[0] <= h_port;
         st_tag[0]  <= h_tag;
         st_code[0] <= r_code;
         st_data[0] <= r_data;
         for (int k = 1; k < LAT; k++) begin
            st_v[k]    <= st_v[k-1];
            st_port[k] <= st_port[k-1];
            st_tag[k]  <= st_tag[k-1];
            st_code[k] <= st_code[k-1];
            st_data[k] <= st_data[k-1];
         end
      end
   end

   assign out_valid = st_v[LAT-1];
   assign out_port  = st_port[LAT-1];
   assign out_tag   = st_tag[LAT-1];
   assign out_code  = st_code[LAT-1];
   assign out_data  = st_data[LAT-1];

   p_code_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_code == RSP_OK || out_code == RSP_ERR));
   p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && out_valid) |=> (out_valid && $stable(out_tag) && $stable(out_port)
                               && $stable(out_data) && $stable(out_code)));
endmodule

// File: rtl/mtc_tagged_calc.sv
module mtc_tagged_calc
   import mtc_pkg::*;
#(
   parameter int NP        = 4,
   parameter int DW        = 32,
   parameter int TW        = 2,
   parameter int QDEPTH    = 4,
   parameter int MAX_OUT   = 4,
   parameter int ARITH_LAT = 1,
   parameter int SHIFT_LAT = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NP-1:0]          req_valid,
   output logic [NP-1:0]          req_ready,
   input  logic [NP-1:0][3:0]     req_op,
   input  logic [NP-1:0][TW-1:0]  req_tag,
   input  logic [NP-1:0][DW-1:0]  req_a,
   input  logic [NP-1:0][DW-1:0]  req_b,
   output logic [NP-1:0]          rsp_valid,
   output logic [NP-1:0][1:0]     rsp_code,
   output logic [NP-1:0][TW-1:0]  rsp_tag,
   output logic [NP-1:0][DW-1:0]  rsp_data
);
   localparam int PW = $clog2(NP);
   localparam int CW = $clog2(MAX_OUT + 1);

   if (NP < 2) begin : g_bad_np
      $error("mtc_tagged_calc: NP must be at least 2");
   end
   if (MAX_OUT < 1 || MAX_OUT > (1 << TW)) begin : g_bad_out
      $error("mtc_tagged_calc: MAX_OUT must lie in 1..2**TW");
   end
   if (DW < 2) begin : g_bad_dw
      $error("mtc_tagged_calc: DW must be at least 2");
   end

   logic [NP-1:0] room, a_req, s_req, a_gnt, s_gnt;
   logic [PW-1:0] a_idx, s_idx;
   logic          a_full, s_full;

   logic          a_v, s_v, s_hold;
   logic [PW-1:0] a_port, s_port;
   logic [TW-1:0] a_tag, s_tag;
   logic [1:0]    a_code, s_code;
   logic [DW-1:0] a_data, s_data;

   logic [CW-1:0] inflight [NP];

   for (genvar p = 0; p < NP; p++) begin : g_port
      logic acc, a_hit, s_hit;

      assign room[p]  = (inflight[p] != CW'(MAX_OUT));
      assign a_req[p] = req_valid[p] && room[p] && !is_shift_op(req_op[p]);
      assign s_req[p] = req_valid[p] && room[p] &&  is_shift_op(req_op[p]);
      assign req_ready[p] = a_gnt[p] | s_gnt[p];
      assign acc = req_valid[p] && req_ready[p];

      always_ff @(posedge clk) begin
         if (!rst_n) inflight[p] <= '0;
         else inflight[p] <= inflight[p] + CW'(acc) - CW'(rsp_valid[p]);
      end

      assign a_hit = a_v && (a_port == PW'(p));
      assign s_hit = s_v && (s_port == PW'(p));

      always_comb begin
         rsp_valid[p] = a_hit | s_hit;
         if (a_hit) begin
            rsp_tag[p]  = a_tag;
            rsp_code[p] = a_code;
            rsp_data[p] = a_data;
         end else if (s_hit) begin
            rsp_tag[p]  = s_tag;
            rsp_code[p] = s_code;
            rsp_data[p] = s_data;
         end else begin
            rsp_tag[p]  = '0;
            rsp_code[p] = RSP_NONE;
            rsp_data[p] = '0;
         end
      end

      p_inflight_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
         inflight[p] <= CW'(MAX_OUT));
      p_ready_when_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (inflight[p] == CW'(MAX_OUT)) |-> !req_ready[p]);
      p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid[p] |-> (inflight[p] != '0));
   end

   mtc_rr_arb #(.N(NP)) u_arb_a (
      .clk(clk), .rst_n(rst_n), .req(a_req), .en(!a_full), .gnt(a_gnt), .idx(a_idx)
   );
   mtc_rr_arb #(.N(NP)) u_arb_s (
      .clk(clk), .rst_n(rst_n), .req(s_req), .en(!s_full), .gnt(s_gnt), .idx(s_idx)
   );

   assign s_hold = s_v && a_v && (a_port == s_port);

   mtc_exec_unit #(.KIND(UNIT_ARITH), .DW(DW), .TW(TW), .PW(PW),
                   .DEPTH(QDEPTH), .LAT(ARITH_LAT)) u_arith (
      .clk(clk), .rst_n(rst_n), .in_push(|a_gnt), .in_port(a_idx),
      .in_tag(req_tag[a_idx]), .in_op(req_op[a_idx]),
      .in_a(req_a[a_idx]), .in_b(req_b[a_idx]), .q_full(a_full), .hold(1'b0),
      .out_valid(a_v), .out_port(a_port), .out_tag(a_tag),
      .out_code(a_code), .out_data(a_data)
   );

   mtc_exec_unit #(.KIND(UNIT_SHIFT), .DW(DW), .TW(TW), .PW(PW),
                   .DEPTH(QDEPTH), .LAT(SHIFT_LAT)) u_shift (
      .clk(clk), .rst_n(rst_n), .in_push(|s_gnt), .in_port(s_idx),
      .in_tag(req_tag[s_idx]), .in_op(req_op[s_idx]),
      .in_a(req_a[s_idx]), .in_b(req_b[s_idx]), .q_full(s_full), .hold(s_hold),
      .out_valid(s_v), .out_port(s_port), .out_tag(s_tag),
      .out_code(s_code), .out_data(s_data)
   );

   p_one_take_per_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_gnt & s_gnt) == '0);
   p_shift_deferred_r9: assert property (@(posedge clk) disable iff (!rst_n)
      s_hold |=> s_v);
endmodule

// File: tb/sim_mtc_tagged_calc.sv
module sim_mtc_tagged_calc;
   localparam int NP = 4;
   localparam int DW = 32;
   localparam int TW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]         req_valid = '0;
   logic [NP-1:0]         req_ready;
   logic [NP-1:0][3:0]    req_op = '0;
   logic [NP-1:0][TW-1:0] req_tag = '0;
   logic [NP-1:0][DW-1:0] req_a = '0;
   logic [NP-1:0][DW-1:0] req_b = '0;
   logic [NP-1:0]         rsp_valid;
   logic [NP-1:0][1:0]    rsp_code;
   logic [NP-1:0][TW-1:0] rsp_tag;
   logic [NP-1:0][DW-1:0] rsp_data;

   always #2.5 clk = ~clk;

   mtc_tagged_calc u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_tag(req_tag), .req_a(req_a), .req_b(req_b),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
   );

   typedef struct {
      logic [1:0]  tag;
      logic [1:0]  code;
      logic [31:0] data;
   } exp_t;

   exp_t qa [NP][$];
   exp_t qs [NP][$];
   int   checks = 0;
   int   errors = 0;
   int   outst [NP];
   int   max_outst [NP];
   logic [1:0] tagc [NP];
   bit   done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [1:0] tag);
      exp_t e;
      logic [32:0] s;
      e.tag = tag;
      s = {1'b0, a} + {1'b0, b};
      case (op)
         4'h1: begin e.data = s[31:0]; e.code = s[32] ? 2'b10 : 2'b01; end
         4'h2: begin e.data = a - b;   e.code = (b > a) ? 2'b10 : 2'b01; end
         4'h5: begin e.data = a << b[4:0]; e.code = 2'b01; end
         4'h6: begin e.data = a >> b[4:0]; e.code = 2'b01; end
         default: begin e.data = 32'h0; e.code = 2'b10; end
      endcase
      return e;
   endfunction

   // driver: presents one command, waits for it to be taken, records the expectation
   task automatic send(input int p, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b);
      exp_t e;
      @(negedge clk);
      req_valid[p] = 1'b1;
      req_op[p]    = op;
      req_tag[p]   = tagc[p];
      req_a[p]     = a;
      req_b[p]     = b;
      #1;
      while (!req_ready[p]) begin
         @(negedge clk);
         #1;
      end
      e = model(op, a, b, tagc[p]);
      if (op == 4'h5 || op == 4'h6) qs[p].push_back(e);
      else qa[p].push_back(e);
      @(posedge clk);
      #1;
      req_valid[p] = 1'b0;
      outst[p]++;
      if (outst[p] > max_outst[p]) max_outst[p] = outst[p];
      tagc[p] = tagc[p] + 2'd1;
   endtask

   // monitor: each response must match the head of its port's arithmetic or shift queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int p = 0; p < NP; p++) begin
            if (rsp_valid[p]) begin
               exp_t e;
               outst[p]--;
               if (qa[p].size() > 0 && qa[p][0].tag == rsp_tag[p]) begin
                  e = qa[p].pop_front();
                  chk(rsp_code[p] == e.code, "R3/R4/R6", "arith code", 64'(rsp_code[p]), 64'(e.code));
                  chk(rsp_data[p] == e.data, "R3/R4/R6", "arith data", 64'(rsp_data[p]), 64'(e.data));
               end else if (qs[p].size() > 0 && qs[p][0].tag == rsp_tag[p]) begin
                  e = qs[p].pop_front();
                  chk(rsp_code[p] == e.code, "R5", "shift code", 64'(rsp_code[p]), 64'(e.code));
                  chk(rsp_data[p] == e.data, "R5", "shift data", 64'(rsp_data[p]), 64'(e.data));
               end else begin
                  chk(1'b0, "R2 R7 R10", "unmatched tag", 64'(rsp_tag[p]), 64'(p));
               end
            end
         end
      end
   end

   task automatic drain();
      for (int i = 0; i < 200; i++) @(negedge clk);
   endtask

   initial begin
      for (int p = 0; p < NP; p++) begin
         outst[p] = 0;
         max_outst[p] = 0;
         tagc[p] = 2'd0;
      end
      repeat (4) @(negedge clk);
      chk(rsp_valid == '0, "R10", "rsp_valid in reset", 64'(rsp_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == '0, "R10", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
      chk(req_ready == '0, "R8", "ready with no request", 64'(req_ready), 64'h0);

      // corner vectors on every port (R3 R4 R5 R6)
      for (int p = 0; p < NP; p++) begin
         send(p, 4'h1, 32'h1234_0000, 32'h0000_5678);
         send(p, 4'h1, 32'hFFFF_FFFE, 32'h0000_0001);
         send(p, 4'h1, 32'hFFFF_FFFF, 32'h0000_0001);
         send(p, 4'h1, 32'h8000_0000, 32'h8000_0000);
         send(p, 4'h2, 32'h0000_0777, 32'h0000_0777);
         send(p, 4'h2, 32'h0000_0010, 32'h0000_0011);
         send(p, 4'h2, 32'h0000_0100, 32'h0000_0001);
         send(p, 4'h5, 32'hA5A5_0001, 32'd0);
         send(p, 4'h5, 32'h0000_0001, 32'd31);
         send(p, 4'h5, 32'h0000_0002, 32'd31);
         send(p, 4'h6, 32'h8000_0000, 32'd31);
         send(p, 4'h6, 32'h0000_0001, 32'd31);
         send(p, 4'h6, 32'hF000_0000, 32'd35);
         send(p, 4'hF, 32'h1, 32'h2);
         send(p, 4'h0, 32'h3, 32'h4);
      end
      drain();

      // directed same-port completion collision (R9)
      begin
         logic [1:0] t_sh, t_ad;
         t_sh = tagc[0];
         send(0, 4'h5, 32'h0000_0003, 32'd4);
         t_ad = tagc[0];
         send(0, 4'h1, 32'd10, 32'd20);
         @(negedge clk);
         chk(rsp_valid[0] == 1'b0, "R9", "no response before latency", 64'(rsp_valid[0]), 64'h0);
         @(negedge clk);
         chk(rsp_valid[0] && rsp_tag[0] == t_ad, "R9", "add answered first", 64'(rsp_tag[0]), 64'(t_ad));
         @(negedge clk);
         chk(rsp_valid[0] && rsp_tag[0] == t_sh, "R9", "shift one cycle later", 64'(rsp_tag[0]), 64'(t_sh));
      end
      drain();

      // concurrent mixed traffic, back-to-back and with gaps (R1 R7 R8)
      fork
         for (int p = 0; p < NP; p++) begin
            automatic int pp = p;
            fork
               for (int i = 0; i < 40; i++) begin
                  logic [3:0] op;
                  case ((i + pp) % 5)
                     0: op = 4'h1;
                     1: op = 4'h5;
                     2: op = 4'h2;
                     3: op = 4'h6;
                     default: op = 4'h5;
                  endcase
                  send(pp, op, 32'hFFFF_FFF0 + 32'(i), 32'(i * 7 + pp));
                  if (pp == 3 && (i % 4) == 0) repeat (3) @(negedge clk);
               end
            join_none
         end
      join
      wait fork;
      drain();

      for (int p = 0; p < NP; p++) begin
         chk(qa[p].size() == 0 && qs[p].size() == 0, "R2 R8", "responses outstanding",
             64'(qa[p].size() + qs[p].size()), 64'h0);
         chk(max_outst[p] <= 4, "R1", "outstanding limit", 64'(max_outst[p]), 64'd4);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog R8 actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule